// File: doc/BRIEF.md
# LCD Row-Scan Timing Generator

This block turns a master clock into the row-scan timing for a multiplexed dot-matrix LCD. It steps a one-hot common-line strobe through the rows of the panel. Every row holds its slot for a fixed number of master clocks. At the start of each slot it pulses a segment-latch strobe, so the column data for the coming row can be loaded.

The panel can be scanned at one of two depths, chosen by a single input: a short scan of 9 rows or a long scan of 17 rows. The block marks the first row of every frame with a frame pulse. It flips an AC-inversion phase once per frame, so one full drive period covers two frames. It also keeps a free-running frame counter and a blink phase that toggles each time that counter wraps. Cursor and character blinking elsewhere can use both.

The scan depth is latched only where one frame ends and the next begins, so a frame never mixes the two depths. After reset the block starts on row 1 in the long scan.

Top module: `lcd_scan_timer`

## Requirements
- R1: Exactly one bit of `com_sel` is high at any time. Bit k selects row k+1. Each row stays selected for `SLOT_CLKS` (64) clocks, and the rows follow in ascending order from bit 0.
- R2: While the short scan is active, bits 16 down to 9 of `com_sel` stay low, and bit 8 is followed by bit 0.
- R3: In the long scan (`duty9` = 0) one frame lasts 17 × 64 = 1088 clocks, and `frame_pulse` is high in the first clock of row 1 only.
- R4: In the short scan (`duty9` = 1) one frame lasts 9 × 64 = 576 clocks, with `frame_pulse` marking the first clock of row 1.
- R5: `seg_latch` is high for exactly one clock at the start of each row slot, which is once every 64 clocks, and is low at all other times.
- R6: `ac_phase` inverts on the clock edge that starts a new frame and holds its value for the rest of the frame.
- R7: `blink_phase` inverts each time a new frame begins with `frame_cnt` at 31, which is once every 32 frames. It never changes at any other time.
- R8: `frame_cnt` counts completed frames, from 0 to 31 and then back to 0, and advances on the edge that starts each new frame.
- R9: While `rst_n` is low, the outputs take their reset state: `com_sel` = 1 (row 1), `frame_pulse` = 1, `seg_latch` = 1, `ac_phase` = 0, `blink_phase` = 0 and `frame_cnt` = 0. Reset is asynchronous.
- R10: A change on `duty9` has no effect on the current frame. The block samples it only on the edge that ends a frame.
- R11: The first frame after reset is a long (17-row) scan, whatever the level of `duty9`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty9 | input | 1 | Scan depth select: 1 = 9 rows, 0 = 17 rows |
| com_sel | output | ROWS_MAX (17) | One-hot common-line strobe, bit 0 = row 1 |
| frame_pulse | output | 1 | High in the first clock of row 1 |
| seg_latch | output | 1 | High in the first clock of every row slot |
| ac_phase | output | 1 | Drive inversion phase, toggles each frame |
| blink_phase | output | 1 | Slow phase, toggles every BLINK_FRAMES frames |
| frame_cnt | output | $clog2(BLINK_FRAMES) (5) | Frame counter modulo BLINK_FRAMES |

## Verification
Errors in the slot counter show up as a missing or misplaced `seg_latch` within 64 clocks. The row pointer is checked against the clock count every cycle, so a skipped row or a wrong frame length is seen on `com_sel` at the first row change that goes wrong. A fault in the latched scan depth shows at the first frame boundary after `duty9` changes: either row 10 is strobed in the short scan, or the wrap to row 1 comes early in the long scan. A faulty frame counter or blink logic may stay hidden for up to 32 frames. For that reason the run crosses two counter wraps, under both scan depths.

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
  parameter int ROWS_MAX     = 17,
  parameter int ROWS_MIN     = 9,
  parameter int SLOT_CLKS    = 64,
  parameter int BLINK_FRAMES = 32,
  localparam int SLOT_W = $clog2(SLOT_CLKS),
  localparam int ROW_W  = $clog2(ROWS_MAX),
  localparam int FC_W   = $clog2(BLINK_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                duty9,
  output logic [ROWS_MAX-1:0] com_sel,
  output logic                frame_pulse,
  output logic                seg_latch,
  output logic                ac_phase,
  output logic                blink_phase,
  output logic [FC_W-1:0]     frame_cnt
);

  logic [SLOT_W-1:0] slot;
  logic [ROW_W-1:0]  row;
  logic              short_mode;

  wire              slot_end  = (slot == SLOT_W'(SLOT_CLKS - 1));
  wire [ROW_W-1:0]  last_row  = short_mode ? ROW_W'(ROWS_MIN - 1) : ROW_W'(ROWS_MAX - 1);
  wire              frame_end = slot_end && (row == last_row);
  wire              fc_wrap   = (frame_cnt == FC_W'(BLINK_FRAMES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot        <= '0;
      row         <= '0;
      short_mode  <= 1'b0;
      ac_phase    <= 1'b0;
      blink_phase <= 1'b0;
      frame_cnt   <= '0;
    end else begin
      slot <= slot_end ? '0 : slot + 1'b1;
      if (slot_end)
        row <= frame_end ? '0 : row + 1'b1;
      if (frame_end) begin
        short_mode <= duty9;
        ac_phase   <= ~ac_phase;
        frame_cnt  <= fc_wrap ? '0 : frame_cnt + 1'b1;
        if (fc_wrap)
          blink_phase <= ~blink_phase;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < ROWS_MAX; i++)
      com_sel[i] = (row == ROW_W'(i));
  end

  assign seg_latch   = (slot == '0);
  assign frame_pulse = seg_latch && (row == '0);

endmodule

// File: rtl/lcd_scan_timer_chk.sv
module lcd_scan_timer_chk #(
  parameter int ROWS_MAX = 17,
  parameter int ROWS_MIN = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                short_mode,
  input logic [ROWS_MAX-1:0] com_sel,
  input logic                frame_pulse,
  input logic                seg_latch,
  input logic                ac_phase,
  input logic                blink_phase
);

  assert_com_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(com_sel));

  assert_upper_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    short_mode |-> (com_sel[ROWS_MAX-1:ROWS_MIN] == '0));

  assert_frame_on_row1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (com_sel[0] && seg_latch));

  assert_latch_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seg_latch |=> !seg_latch);

  assert_ac_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_pulse |-> $stable(ac_phase));

  assert_blink_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_pulse |-> $stable(blink_phase));

endmodule

bind lcd_scan_timer lcd_scan_timer_chk #(.ROWS_MAX(ROWS_MAX), .ROWS_MIN(ROWS_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .short_mode(short_mode), .com_sel(com_sel),
  .frame_pulse(frame_pulse), .seg_latch(seg_latch), .ac_phase(ac_phase),
  .blink_phase(blink_phase));

// File: tb/lcd_scan_timer_tb.sv
module lcd_scan_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic duty9 = 1'b0;
  logic [16:0] com_sel;
  logic frame_pulse, seg_latch, ac_phase, blink_phase;
  logic [4:0] frame_cnt;

  always #2 clk = ~clk;

  lcd_scan_timer u_dut (
    .clk(clk), .rst_n(rst_n), .duty9(duty9), .com_sel(com_sel),
    .frame_pulse(frame_pulse), .seg_latch(seg_latch), .ac_phase(ac_phase),
    .blink_phase(blink_phase), .frame_cnt(frame_cnt));

  typedef struct {
    logic [16:0] com;
    logic        fp;
    logic        sl;
    logic        ac;
    logic        bl;
    logic [4:0]  fc;
    int          rows;
    bit          pending;
    bit          first;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  int m_slot = 0, m_row = 0, m_rows = 17, m_frames = 0;
  logic m_ac = 0, m_bl = 0;
  logic [4:0] m_fc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // predictor: pushes the expected outputs after each edge
  always @(posedge clk) begin
    exp_t e;
    if (!rst_n) begin
      m_slot = 0; m_row = 0; m_rows = 17; m_frames = 0;
      m_ac = 0; m_bl = 0; m_fc = 0;
    end else if (m_slot == 63) begin
      m_slot = 0;
      if (m_row == m_rows - 1) begin
        m_row = 0;
        m_rows = duty9 ? 9 : 17;
        m_ac = ~m_ac;
        m_frames++;
        if (m_fc == 5'd31) begin m_fc = 0; m_bl = ~m_bl; end
        else m_fc = m_fc + 5'd1;
      end else m_row++;
    end else m_slot++;
    e.com = 17'd1 << m_row;
    e.fp = (m_slot == 0) && (m_row == 0);
    e.sl = (m_slot == 0);
    e.ac = m_ac; e.bl = m_bl; e.fc = m_fc;
    e.rows = m_rows;
    e.pending = (duty9 ? 9 : 17) != m_rows;
    e.first = (m_frames == 0);
    q.push_back(e);
  end

  // monitor: pops and compares away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      string x;
      e = q.pop_front();
      if (!rst_n) begin
        chk(com_sel == 17'd1, "R9 com_sel", com_sel, 1);
        chk(frame_pulse && seg_latch, "R9 pulses", {frame_pulse, seg_latch}, 3);
        chk(!ac_phase && !blink_phase && frame_cnt == 0, "R9 phases/count",
            {ac_phase, blink_phase, frame_cnt}, 0);
      end else begin
        x = {e.pending ? " R10" : "", e.first ? " R11" : ""};
        chk(com_sel == e.com, {"R1", (e.rows == 9) ? " R2" : "", x, " com_sel"}, com_sel, e.com);
        chk(frame_pulse == e.fp, {(e.rows == 9) ? "R4" : "R3", x, " frame_pulse"}, frame_pulse, e.fp);
        chk(seg_latch == e.sl, {"R5", x, " seg_latch"}, seg_latch, e.sl);
        chk(ac_phase == e.ac, {"R6", x, " ac_phase"}, ac_phase, e.ac);
        chk(blink_phase == e.bl, {"R7 blink_phase"}, blink_phase, e.bl);
        chk(frame_cnt == e.fc, {"R8", x, " frame_cnt"}, frame_cnt, e.fc);
      end
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R11: duty9 high during reset; first frame must still be 17 rows
    duty9 = 1;
    wait_cycles(5);
    rst_n = 1;
    wait_cycles(1088 + 64 * 3);      // then 9-row frames follow
    wait_cycles(576 * 3);
    // R10: switch to 17 rows in the middle of a frame
    wait_cycles(100);
    duty9 = 0;
    wait_cycles(1088 * 4);
    // R10: back to 9 rows mid-frame, then run long enough to wrap the counter (R7, R8)
    wait_cycles(300);
    duty9 = 1;
    wait_cycles(576 * 40);
    // 17-row stretch crossing the second wrap
    wait_cycles(37);
    duty9 = 0;
    wait_cycles(1088 * 30);
    // R9: asynchronous reset mid-frame
    wait_cycles(211);
    rst_n = 0;
    wait_cycles(4);
    rst_n = 1;
    wait_cycles(2500);
    finish_run();
  end
endmodule